// File: doc/BRIEF.md
# Pipelined CPU Interrupt Acceptance Unit

This block sits next to a CPU pipeline and decides in which cycle a pending nonreset interrupt is taken. Each external request line passes through a fixed synchronizer. A rising edge that reaches the end of the synchronizer sets a pending flag for that line. Pending flags are gated by a per-line enable and by two control bits. The global enable gates the maskable lines. The nonmaskable enable gates every line, including the nonmaskable one.

The pipeline reports the start of each execute packet with a valid strobe and a bit that says whether the packet holds a branch. A branch counts whether or not it is taken. The unit keeps a short history of recent packets. It refuses to accept an interrupt while any of those packets held a branch or sat in a branch's delay slots.

When an interrupt is accepted, the unit does four things in the same cycle:
- it pulses an acknowledge;
- it presents the interrupt number;
- it asks the pipeline to annul younger packets;
- it asks fetch to restart at the line's service vector.

A fixed blackout window then holds off the next acceptance.

Top module: `irq_accept_unit`

## Requirements
- R1: A synchronous reset clears all pending flags, the synchronizers, the packet history, the delay-slot count and the blackout count. After reset `iack`, `annul` and `fetch_req` are 0, `inum` is 0 and `fetch_addr` is 0, and no request seen before reset is ever acknowledged.
- R2: Only a rising edge on a request line makes a request; a line held high requests once. The pin is sampled at clock edge E0 (high at E0, low at the previous edge). If the request is eligible, `iack` is high in the cycle after edge E(SYNC_DELAY+1), which is 6 cycles after E0 with defaults.
- R3: Line i (bit i of `irq_pin`) is interrupt number i+1, presented on `inum` during `iack`. Line 0 is nonmaskable and lines 1 and up are maskable. `inum` is 0 whenever `iack` is 0.
- R4: When several eligible lines are pending, the lowest line index is acknowledged first. The others stay pending and are taken later in increasing index order.
- R5: A maskable line is not acknowledged while `gie` is 0 and stays pending. If it is pending and otherwise eligible, `iack` follows one cycle after `gie` rises. `gie` does not affect line 0.
- R6: No line, line 0 included, is acknowledged while `nmie` is 0. Pending requests are taken once `nmie` is 1, the first one cycle later.
- R7: Bit i of `line_en` gates maskable line i. A disabled pending line stays pending and is taken one cycle after it is enabled. `line_en[0]` has no effect on line 0.
- R8: Acceptance is blocked while any of the last HIST_DEPTH (5) reported packets held a branch or lay in the DELAY_SLOTS (5) packets after a branch; a branch inside delay slots restarts the slot count. The history advances only on `pkt_valid`, so with the defaults a pending request is taken one cycle after the tenth clean packet that follows the last branch.
- R9: `iack` is a one-cycle pulse. At least BLACKOUT (7) cycles without `iack` separate two pulses. When requests are waiting and nothing else blocks them, consecutive pulses are exactly BLACKOUT+1 cycles apart.
- R10: The flag of an acknowledged line is cleared in the acknowledge cycle. Extra rising edges on a line whose flag is already pending produce no further acknowledge.
- R11: `annul` and `fetch_req` are high exactly when `iack` is high. At that time `fetch_addr` equals VEC_BASE + (`inum` << VEC_SHIFT); with the bench's VEC_BASE of 0x4000 and shift of 5, line 2 gives 0x4060.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_pin | input | NUM_LINES | External request lines; bit 0 is nonmaskable |
| gie | input | 1 | Global enable for maskable lines |
| nmie | input | 1 | Enable for all nonreset lines |
| line_en | input | NUM_LINES | Per-line enable for maskable lines |
| pkt_valid | input | 1 | An execute packet starts this cycle |
| pkt_branch | input | 1 | That packet holds a branch, taken or not |
| iack | output | 1 | Acknowledge pulse |
| inum | output | NUM_W | Number of the acknowledged interrupt, 0 otherwise |
| annul | output | 1 | Annul younger execute packets |
| fetch_req | output | 1 | Redirect fetch to the service vector |
| fetch_addr | output | ADDR_W | Service vector address |

## Verification
Every result is registered, so a change of any gate takes effect one cycle after the negedge at which the bench drives it, and a fresh pin edge reaches `iack` SYNC_DELAY+2 negedges later. The bench numbers the negedges after each stimulus and records the index at which each acknowledge appears. It then compares that index with the arithmetic expectation: 6 for a fresh edge, 6 + 8k for the k-th of several simultaneous requests, one more than the count of packets needed to clear the history, and 1 after a gate opens. Side outputs are compared in the same sampled cycle as each acknowledge.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

   // width needed to carry interrupt numbers 0..n (0 means "none")
   function automatic int unsigned num_width(input int unsigned n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

   // outputs that move together on an acceptance
   typedef struct packed {
      logic ack;
      logic kill;
      logic redirect;
   } accept_pulse_t;

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
   parameter int NUM_LINES  = 8,
   parameter int SYNC_DELAY = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_LINES-1:0] pin,
   input  logic [NUM_LINES-1:0] clr,
   output logic [NUM_LINES-1:0] flag
);
   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      logic [SYNC_DELAY-1:0] stage;
      logic                  last_q;
      logic                  rise;
      logic                  flag_q;

      if (SYNC_DELAY == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) stage <= '0;
            else     stage <= pin[g];
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (rst) stage <= '0;
            else     stage <= {stage[SYNC_DELAY-2:0], pin[g]};
         end
      end

      always_ff @(posedge clk) begin
         if (rst) last_q <= 1'b0;
         else     last_q <= stage[SYNC_DELAY-1];
      end

      assign rise = stage[SYNC_DELAY-1] & ~last_q;

      // a new edge wins over a same-cycle clear; a held flag absorbs repeats
      always_ff @(posedge clk) begin
         if (rst)       flag_q <= 1'b0;
         else if (rise) flag_q <= 1'b1;
         else if (clr[g]) flag_q <= 1'b0;
      end

      assign flag[g] = flag_q;
   end
endmodule

// File: rtl/irq_branch_track.sv
module irq_branch_track #(
   parameter int HIST_DEPTH  = 5,
   parameter int DELAY_SLOTS = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic pkt_valid,
   input  logic pkt_branch,
   output logic block
);
   localparam int SLOT_W = (DELAY_SLOTS < 1) ? 1 : $clog2(DELAY_SLOTS + 1);

   logic                  shadowed;
   logic [HIST_DEPTH-1:0] hist;

   if (DELAY_SLOTS == 0) begin : g_noslot
      assign shadowed = pkt_branch;
   end else begin : g_slot
      logic [SLOT_W-1:0] slot_cnt;
      assign shadowed = pkt_branch | (slot_cnt != '0);
      always_ff @(posedge clk) begin
         if (rst) begin
            slot_cnt <= '0;
         end else if (pkt_valid) begin
            if (pkt_branch)          slot_cnt <= SLOT_W'(DELAY_SLOTS);
            else if (slot_cnt != '0) slot_cnt <= slot_cnt - 1'b1;
         end
      end
   end

   if (HIST_DEPTH == 1) begin : g_h1
      always_ff @(posedge clk) begin
         if (rst)            hist <= '0;
         else if (pkt_valid) hist <= shadowed;
      end
   end else begin : g_hn
      always_ff @(posedge clk) begin
         if (rst)            hist <= '0;
         else if (pkt_valid) hist <= {hist[HIST_DEPTH-2:0], shadowed};
      end
   end

   assign block = |hist;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int NUM_LINES = 8,
   parameter int NUM_W     = 4
) (
   input  logic [NUM_LINES-1:0] req,
   output logic                 any,
   output logic [NUM_LINES-1:0] grant,
   output logic [NUM_W-1:0]     num
);
   always_comb begin
      grant = '0;
      num   = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            num      = NUM_W'(i + 1);
         end
      end
   end
   assign any = |req;
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
   import irq_accept_pkg::*;
#(
   parameter int          NUM_LINES   = 8,
   parameter int          SYNC_DELAY  = 4,
   parameter int          HIST_DEPTH  = 5,
   parameter int          DELAY_SLOTS = 5,
   parameter int          BLACKOUT    = 7,
   parameter int          ADDR_W      = 32,
   parameter int          VEC_SHIFT   = 5,
   parameter logic [63:0] VEC_BASE    = 64'h0,
   localparam int         NUM_W       = num_width(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_LINES-1:0] irq_pin,
   input  logic                 gie,
   input  logic                 nmie,
   input  logic [NUM_LINES-1:0] line_en,
   input  logic                 pkt_valid,
   input  logic                 pkt_branch,
   output logic                 iack,
   output logic [NUM_W-1:0]     inum,
   output logic                 annul,
   output logic                 fetch_req,
   output logic [ADDR_W-1:0]    fetch_addr
);
   localparam int BO_W = (BLACKOUT < 1) ? 1 : $clog2(BLACKOUT + 1);

   if (NUM_LINES < 2)              begin : g_chk_lines  $error("NUM_LINES must be at least 2"); end
   if (SYNC_DELAY < 1)             begin : g_chk_sync   $error("SYNC_DELAY must be at least 1"); end
   if (HIST_DEPTH < 1)             begin : g_chk_hist   $error("HIST_DEPTH must be at least 1"); end
   if (DELAY_SLOTS < 0)            begin : g_chk_slots  $error("DELAY_SLOTS must not be negative"); end
   if (BLACKOUT < 0)               begin : g_chk_bo     $error("BLACKOUT must not be negative"); end
   if (ADDR_W < 1 || ADDR_W > 64)  begin : g_chk_addr   $error("ADDR_W must be 1..64"); end
   if (VEC_SHIFT + NUM_W > ADDR_W) begin : g_chk_vec    $error("vector offsets exceed ADDR_W"); end

   logic [NUM_LINES-1:0] flag;
   logic [NUM_LINES-1:0] clr;
   logic [NUM_LINES-1:0] eligible;
   logic [NUM_LINES-1:0] grant;
   logic [NUM_W-1:0]     pick_num;
   logic                 pick_any;
   logic                 branch_block;
   logic                 blackout_busy;
   logic                 take;
   accept_pulse_t        pulse_q;
   logic [NUM_W-1:0]     inum_q;
   logic [ADDR_W-1:0]    addr_q;

   irq_line_sync #(
      .NUM_LINES (NUM_LINES),
      .SYNC_DELAY(SYNC_DELAY)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .pin (irq_pin),
      .clr (clr),
      .flag(flag)
   );

   irq_branch_track #(
      .HIST_DEPTH (HIST_DEPTH),
      .DELAY_SLOTS(DELAY_SLOTS)
   ) u_branch (
      .clk       (clk),
      .rst       (rst),
      .pkt_valid (pkt_valid),
      .pkt_branch(pkt_branch),
      .block     (branch_block)
   );

   // line 0 answers only to nmie; the rest also need gie and their enable
   always_comb begin
      eligible    = flag & line_en & {NUM_LINES{gie & nmie}};
      eligible[0] = flag[0] & nmie;
   end

   irq_pick #(
      .NUM_LINES(NUM_LINES),
      .NUM_W    (NUM_W)
   ) u_pick (
      .req  (eligible),
      .any  (pick_any),
      .grant(grant),
      .num  (pick_num)
   );

   if (BLACKOUT == 0) begin : g_noblk
      assign blackout_busy = 1'b0;
   end else begin : g_blk
      logic [BO_W-1:0] bo_cnt;
      always_ff @(posedge clk) begin
         if (rst)                bo_cnt <= '0;
         else if (take)          bo_cnt <= BO_W'(BLACKOUT);
         else if (bo_cnt != '0)  bo_cnt <= bo_cnt - 1'b1;
      end
      assign blackout_busy = (bo_cnt != '0);
   end

   assign take = pick_any & ~branch_block & ~blackout_busy;
   assign clr  = grant & {NUM_LINES{take}};

   always_ff @(posedge clk) begin
      if (rst || !take) begin
         pulse_q <= '0;
         inum_q  <= '0;
         addr_q  <= '0;
      end else begin
         pulse_q <= '{ack: 1'b1, kill: 1'b1, redirect: 1'b1};
         inum_q  <= pick_num;
         addr_q  <= VEC_BASE[ADDR_W-1:0] + (ADDR_W'(pick_num) << VEC_SHIFT);
      end
   end

   assign iack       = pulse_q.ack;
   assign annul      = pulse_q.kill;
   assign fetch_req  = pulse_q.redirect;
   assign inum       = inum_q;
   assign fetch_addr = addr_q;
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
   parameter int NUM_LINES = 8,
   parameter int NUM_W     = 4,
   parameter int BLACKOUT  = 7
) (
   input logic             clk,
   input logic             rst,
   input logic             gie,
   input logic             nmie,
   input logic             iack,
   input logic [NUM_W-1:0] inum,
   input logic             annul,
   input logic             fetch_req,
   input logic             branch_block
);
   localparam int GAP_W = $clog2(BLACKOUT + 2) + 1;
   localparam logic [GAP_W-1:0] GAP_SAT = {GAP_W{1'b1}};

   logic [GAP_W-1:0] gap;
   always_ff @(posedge clk) begin
      if (rst)               gap <= GAP_SAT;
      else if (iack)         gap <= '0;
      else if (gap != GAP_SAT) gap <= gap + 1'b1;
   end

   assert_idle_num_R3: assert property (@(posedge clk) disable iff (rst)
      !iack |-> inum == '0);
   assert_num_range_R3: assert property (@(posedge clk) disable iff (rst)
      iack |-> (inum != '0 && int'(inum) <= NUM_LINES));
   assert_gie_gate_R5: assert property (@(posedge clk) disable iff (rst)
      (iack && inum > NUM_W'(1)) |-> $past(gie));
   assert_nmie_gate_R6: assert property (@(posedge clk) disable iff (rst)
      iack |-> $past(nmie));
   assert_branch_gate_R8: assert property (@(posedge clk) disable iff (rst)
      iack |-> !$past(branch_block));
   assert_blackout_gap_R9: assert property (@(posedge clk) disable iff (rst)
      iack |-> (gap == GAP_SAT || int'(gap) >= BLACKOUT));
   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      iack |=> !iack);
   assert_side_pulses_R11: assert property (@(posedge clk) disable iff (rst)
      (iack || annul || fetch_req) |-> (iack && annul && fetch_req));
endmodule

bind irq_accept_unit irq_accept_chk #(
   .NUM_LINES(NUM_LINES),
   .NUM_W    (NUM_W),
   .BLACKOUT (BLACKOUT)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .gie         (gie),
   .nmie        (nmie),
   .iack        (iack),
   .inum        (inum),
   .annul       (annul),
   .fetch_req   (fetch_req),
   .branch_block(branch_block)
);

// File: tb/irq_accept_unit_bench.sv
module irq_accept_unit_bench;
   localparam int NL  = 4;
   localparam int SD  = 4;
   localparam int BO  = 7;
   localparam int AW  = 32;
   localparam int VS  = 5;
   localparam logic [63:0] VB = 64'h4000;
   localparam int NW  = $clog2(NL + 1);
   localparam int LAT = SD + 2;
   localparam int GAP = BO + 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NL-1:0] irq_pin = '0;
   logic          gie = 1'b1;
   logic          nmie = 1'b1;
   logic [NL-1:0] line_en = '1;
   logic          pkt_valid = 1'b0;
   logic          pkt_branch = 1'b0;
   logic          iack;
   logic [NW-1:0] inum;
   logic          annul;
   logic          fetch_req;
   logic [AW-1:0] fetch_addr;

   irq_accept_unit #(
      .NUM_LINES(NL), .SYNC_DELAY(SD), .HIST_DEPTH(5), .DELAY_SLOTS(5),
      .BLACKOUT(BO), .ADDR_W(AW), .VEC_SHIFT(VS), .VEC_BASE(VB)
   ) u_irq_accept_unit (
      .clk(clk), .rst(rst), .irq_pin(irq_pin), .gie(gie), .nmie(nmie),
      .line_en(line_en), .pkt_valid(pkt_valid), .pkt_branch(pkt_branch),
      .iack(iack), .inum(inum), .annul(annul), .fetch_req(fetch_req),
      .fetch_addr(fetch_addr)
   );

   always #2 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int ev_cnt;
   int ev_cyc [0:15];
   int ev_num [0:15];
   int side_bad;
   int idle_bad;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic sample(input int c);
      if (iack) begin
         if (ev_cnt < 16) begin
            ev_cyc[ev_cnt] = c;
            ev_num[ev_cnt] = int'(inum);
         end
         ev_cnt++;
         if (!annul || !fetch_req ||
             fetch_addr != AW'(VB + (64'(inum) << VS))) side_bad++;
      end else if (inum != '0 || annul || fetch_req) begin
         idle_bad++;
      end
   endtask

   // caller is at a negedge; pins drop after one sampled edge
   task automatic run(input int n, input int drop_pkt_at);
      ev_cnt = 0;
      for (int c = 1; c <= n; c++) begin
         @(negedge clk);
         sample(c);
         if (c == 1) irq_pin = '0;
         if (c == drop_pkt_at) pkt_valid = 1'b0;
      end
   endtask

   function automatic int lowest_from(input int mask, input int k);
      int seen = 0;
      for (int i = 0; i < NL; i++) begin
         if (mask[i]) begin
            if (seen == k) return i;
            seen++;
         end
      end
      return -1;
   endfunction

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      side_bad = 0;
      idle_bad = 0;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      check(!iack && inum == '0 && !annul && !fetch_req && fetch_addr == '0,
            "R1", "outputs after reset", {iack, inum, annul, fetch_req}, 0);

      // R2 R3 R11: single edge on each line
      for (int i = 0; i < NL; i++) begin
         irq_pin = NL'(1) << i;
         run(20, 0);
         check(ev_cnt == 1, "R2", "ack count single edge", ev_cnt, 1);
         check(ev_cyc[0] == LAT, "R2", "pin to iack cycles", ev_cyc[0], LAT);
         check(ev_num[0] == i + 1, "R3", "inum of line", ev_num[0], i + 1);
      end

      // R4 R9: every subset of lines at once
      for (int m = 1; m < (1 << NL); m++) begin
         int pc;
         pc = $countones(m);
         irq_pin = NL'(m);
         run(LAT + GAP * NL + 4, 0);
         check(ev_cnt == pc, "R4", "acks for mask", ev_cnt, pc);
         for (int k = 0; k < pc; k++) begin
            check(ev_num[k] == lowest_from(m, k) + 1, "R4", "priority order",
                  ev_num[k], lowest_from(m, k) + 1);
            check(ev_cyc[k] == LAT + GAP * k, "R9", "blackout spacing",
                  ev_cyc[k], LAT + GAP * k);
         end
      end

      // R2: a held level requests once
      irq_pin = 4'b0010;
      ev_cnt = 0;
      for (int c = 1; c <= 30; c++) begin
         @(negedge clk);
         sample(c);
      end
      irq_pin = '0;
      check(ev_cnt == 1, "R2", "held level ack count", ev_cnt, 1);
      run(10, 0);

      // R5: gie gates maskable lines only
      gie = 1'b0;
      irq_pin = 4'b0100;
      run(20, 0);
      check(ev_cnt == 0, "R5", "maskable acked with gie low", ev_cnt, 0);
      gie = 1'b1;
      run(10, 0);
      check(ev_cnt == 1 && ev_cyc[0] == 1 && ev_num[0] == 3, "R5",
            "ack after gie rises (cycle)", ev_cyc[0], 1);
      gie = 1'b0;
      irq_pin = 4'b0001;
      run(20, 0);
      check(ev_cnt == 1 && ev_cyc[0] == LAT && ev_num[0] == 1, "R5",
            "nonmaskable with gie low (cycle)", ev_cyc[0], LAT);
      gie = 1'b1;

      // R6: nmie gates every line
      nmie = 1'b0;
      irq_pin = 4'b0011;
      run(20, 0);
      check(ev_cnt == 0, "R6", "ack with nmie low", ev_cnt, 0);
      nmie = 1'b1;
      run(20, 0);
      check(ev_cnt == 2, "R6", "acks after nmie rises", ev_cnt, 2);
      check(ev_cyc[0] == 1 && ev_num[0] == 1, "R6", "first ack cycle",
            ev_cyc[0], 1);
      check(ev_cyc[1] == 1 + GAP && ev_num[1] == 2, "R9", "second ack cycle",
            ev_cyc[1], 1 + GAP);

      // R7: per-line enable
      line_en = 4'b1101;
      irq_pin = 4'b0010;
      run(20, 0);
      check(ev_cnt == 0, "R7", "disabled line acked", ev_cnt, 0);
      line_en = 4'b1111;
      run(10, 0);
      check(ev_cnt == 1 && ev_cyc[0] == 1 && ev_num[0] == 2, "R7",
            "ack after enable (cycle)", ev_cyc[0], 1);
      line_en = 4'b1110;
      irq_pin = 4'b0001;
      run(20, 0);
      check(ev_cnt == 1 && ev_num[0] == 1, "R7", "line 0 ignores its enable",
            ev_cnt, 1);
      line_en = 4'b1111;

      // R10: repeated edges while pending do not queue
      gie = 1'b0;
      irq_pin = 4'b1000;
      run(3, 0);
      irq_pin = 4'b1000;
      run(20, 0);
      gie = 1'b1;
      run(25, 0);
      check(ev_cnt == 1 && ev_num[0] == 4, "R10", "acks after repeated edges",
            ev_cnt, 1);

      // R8: branch history blocks until ten clean packets
      pkt_valid = 1'b1;
      pkt_branch = 1'b1;
      @(negedge clk);
      pkt_valid = 1'b0;
      pkt_branch = 1'b0;
      irq_pin = 4'b0010;
      run(20, 0);
      check(ev_cnt == 0, "R8", "ack while history blocked", ev_cnt, 0);
      pkt_valid = 1'b1;
      run(20, 10);
      check(ev_cnt == 1 && ev_cyc[0] == 11, "R8", "ack after clean packets",
            ev_cyc[0], 11);

      // R8: branch inside delay slots restarts the count
      ev_cnt = 0;
      irq_pin = 4'b0001;
      pkt_valid = 1'b1;
      pkt_branch = 1'b1;
      for (int c = 1; c <= 30; c++) begin
         @(negedge clk);
         sample(c);
         if (c == 1) irq_pin = '0;
         pkt_branch = (c == 3);
         if (c == 14) pkt_valid = 1'b0;
      end
      check(ev_cnt == 1 && ev_cyc[0] == 15, "R8", "nested branch release",
            ev_cyc[0], 15);

      // R1: reset drops a pending request
      irq_pin = 4'b0001;
      run(3, 0);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      run(20, 0);
      check(ev_cnt == 0, "R1", "ack after reset of pending", ev_cnt, 0);

      check(side_bad == 0, "R11", "annul/fetch mismatches", side_bad, 0);
      check(idle_bad == 0, "R3", "idle cycles with nonzero outputs", idle_bad, 0);

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule